// File: doc/BRIEF.md
# Signed/Unsigned Fractional Multiplier

This block is the multiply unit of a small microcontroller core. It takes two 8-bit operands and a mode code. It returns a 16-bit product split into a high byte and a low byte, which the core always stores in the same fixed register pair, high byte in the upper register. The block does not write the register file itself.

Three signedness combinations are supported: both operands unsigned, both signed, and signed first operand times unsigned second operand. Each combination also has a fractional form. In that form the operands are read as 1.7 fixed-point values and the result is moved one bit toward the most significant end, giving a 1.15 value. Only two flags come out. The carry flag is bit 15 of the product before any shift. The zero flag marks a final 16-bit result of zero.

A one-cycle start strobe launches an operation. The done output pulses for one cycle exactly two cycles later, and the result is valid while done is high. Operations may be launched on back-to-back cycles. Outputs hold their last value until the next operation completes.

Top module: `fracmul_unit`

## Requirements
- R1: Mode code 0 (bits [1:0] = 00, bit 2 = 0) returns the unsigned 16-bit product of op_a_i and op_b_i.
- R2: Mode code 1 (bits [1:0] = 01) treats both operands as two's complement, and the 16-bit result is the two's-complement product.
- R3: Mode code 2 (bits [1:0] = 10) treats op_a_i as signed and op_b_i as unsigned, and the 16-bit result is the two's-complement product.
- R4: Mode bit 2 set selects the fractional form: the result is the integer product of the same signedness, shifted left by one with bit 0 equal to 0.
- R5: flag_c_o equals bit 15 of the unshifted 16-bit product in every mode.
- R6: flag_z_o is 1 exactly when the final 16-bit result {prod_hi_o, prod_lo_o} is zero.
- R7: done_o is 1 during the second cycle after a cycle with start_i high, and only then, so each start gives one single-cycle pulse.
- R8: prod_hi_o, prod_lo_o, flag_z_o and flag_c_o keep their values in every cycle in which no result completes.
- R9: While reset is asserted and right after it, every output is 0.
- R10: The reserved signedness code (bits [1:0] = 11) behaves as unsigned, in both integer and fractional form.
- R11: The signed fractional case 0x80 times 0x80 (-1.0 times -1.0) gives 0x8000 with flag_c_o = 0 and flag_z_o = 0.
- R12: Starts on consecutive cycles give results on consecutive cycles, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, acted on at the clock edge |
| start_i | input | 1 | Launches an operation using this cycle's operands and mode |
| mode_i | input | 3 | Bits [1:0] signedness, bit 2 fractional |
| op_a_i | input | 8 | First operand, the signed one in mixed mode |
| op_b_i | input | 8 | Second operand |
| prod_hi_o | output | 8 | Result bits 15..8 |
| prod_lo_o | output | 8 | Result bits 7..0 |
| flag_z_o | output | 1 | Zero flag of the result |
| flag_c_o | output | 1 | Carry flag, bit 15 of the unshifted product |
| done_o | output | 1 | One-cycle pulse when the result is valid |

## Verification
The assertions check several properties on every cycle. Each start moves through the staging register into a done pulse, an idle stage produces no pulse, outputs stay frozen between completions, and a fractional result always ends in a zero bit. The arithmetic itself, the two flags, the reserved code, the -1.0 times -1.0 corner and the ordering of back-to-back results can only be shown by the bench's scenarios. In those scenarios, random and directed operands are compared with a separate model of each mode.

// File: rtl/fracmul_pkg.sv
package fracmul_pkg;

   localparam int MODE_W   = 3;
   localparam int FRAC_BIT = 2;

   typedef enum logic [1:0] {
      SGN_UU  = 2'b00,
      SGN_SS  = 2'b01,
      SGN_SU  = 2'b10,
      SGN_RSV = 2'b11
   } sign_mode_e;

   typedef struct packed {
      logic a_signed;
      logic b_signed;
      logic frac;
   } op_ctrl_t;

   function automatic op_ctrl_t decode_mode(input logic [MODE_W-1:0] m);
      op_ctrl_t c;
      sign_mode_e s;
      s = sign_mode_e'(m[1:0]);
      c.frac = m[FRAC_BIT];
      unique case (s)
         SGN_SS:  begin c.a_signed = 1'b1; c.b_signed = 1'b1; end
         SGN_SU:  begin c.a_signed = 1'b1; c.b_signed = 1'b0; end
         default: begin c.a_signed = 1'b0; c.b_signed = 1'b0; end
      endcase
      return c;
   endfunction

endpackage

// File: rtl/fracmul_operand_prep.sv
module fracmul_operand_prep
   import fracmul_pkg::*;
#(
   parameter int WIDTH = 8,
   localparam int PW = 2 * WIDTH
) (
   input  logic [WIDTH-1:0]  a_i,
   input  logic [WIDTH-1:0]  b_i,
   input  logic [MODE_W-1:0] mode_i,
   output logic [PW-1:0]     a_ext_o,
   output logic [PW-1:0]     b_ext_o,
   output logic              frac_o
);

   op_ctrl_t ctrl;
   logic     a_fill;
   logic     b_fill;

   always_comb begin
      ctrl    = decode_mode(mode_i);
      a_fill  = ctrl.a_signed & a_i[WIDTH-1];
      b_fill  = ctrl.b_signed & b_i[WIDTH-1];
      a_ext_o = {{WIDTH{a_fill}}, a_i};
      b_ext_o = {{WIDTH{b_fill}}, b_i};
      frac_o  = ctrl.frac;
   end

endmodule

// File: rtl/fracmul_core.sv
module fracmul_core #(
   parameter int WIDTH      = 8,
   parameter int MULT_STYLE = 1,
   localparam int PW = 2 * WIDTH
) (
   input  logic [PW-1:0] a_i,
   input  logic [PW-1:0] b_i,
   output logic [PW-1:0] prod_o
);

   generate
      if (MULT_STYLE == 0) begin : g_infer
         assign prod_o = a_i * b_i;
      end else begin : g_array
         always_comb begin
            logic [PW-1:0] acc;
            acc = '0;
            for (int i = 0; i < PW; i++) begin
               if (b_i[i]) acc = acc + (a_i << i);
            end
            prod_o = acc;
         end
      end
   endgenerate

endmodule

// File: rtl/fracmul_finish.sv
module fracmul_finish #(
   parameter int WIDTH = 8,
   localparam int PW = 2 * WIDTH
) (
   input  logic [PW-1:0] raw_i,
   input  logic          frac_i,
   output logic [PW-1:0] result_o,
   output logic          carry_o,
   output logic          zero_o
);

   always_comb begin
      carry_o  = raw_i[PW-1];
      result_o = frac_i ? {raw_i[PW-2:0], 1'b0} : raw_i;
      zero_o   = (result_o == '0);
   end

endmodule

// File: rtl/fracmul_unit.sv
module fracmul_unit
   import fracmul_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter int MULT_STYLE = 1,
   localparam int PW = 2 * WIDTH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic [WIDTH-1:0]  op_a_i,
   input  logic [WIDTH-1:0]  op_b_i,
   output logic [WIDTH-1:0]  prod_hi_o,
   output logic [WIDTH-1:0]  prod_lo_o,
   output logic              flag_z_o,
   output logic              flag_c_o,
   output logic              done_o
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("fracmul_unit: WIDTH must be at least 2");
      end
      if (MULT_STYLE != 0 && MULT_STYLE != 1) begin : g_bad_style
         $error("fracmul_unit: MULT_STYLE must be 0 or 1");
      end
   endgenerate

   logic [PW-1:0] a_ext, b_ext;
   logic          frac_d;
   logic [PW-1:0] a_q, b_q;
   logic          frac_q;
   logic          stg_vld;
   logic [PW-1:0] raw;
   logic [PW-1:0] result;
   logic          carry, zero;
   logic [PW-1:0] prod_q;
   logic          z_q, c_q, done_q;

   fracmul_operand_prep #(.WIDTH(WIDTH)) u_prep (
      .a_i     (op_a_i),
      .b_i     (op_b_i),
      .mode_i  (mode_i),
      .a_ext_o (a_ext),
      .b_ext_o (b_ext),
      .frac_o  (frac_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q     <= '0;
         b_q     <= '0;
         frac_q  <= 1'b0;
         stg_vld <= 1'b0;
      end else begin
         stg_vld <= start_i;
         if (start_i) begin
            a_q    <= a_ext;
            b_q    <= b_ext;
            frac_q <= frac_d;
         end
      end
   end

   fracmul_core #(.WIDTH(WIDTH), .MULT_STYLE(MULT_STYLE)) u_core (
      .a_i    (a_q),
      .b_i    (b_q),
      .prod_o (raw)
   );

   fracmul_finish #(.WIDTH(WIDTH)) u_finish (
      .raw_i    (raw),
      .frac_i   (frac_q),
      .result_o (result),
      .carry_o  (carry),
      .zero_o   (zero)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prod_q <= '0;
         z_q    <= 1'b0;
         c_q    <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= stg_vld;
         if (stg_vld) begin
            prod_q <= result;
            z_q    <= zero;
            c_q    <= carry;
         end
      end
   end

   assign prod_hi_o = prod_q[PW-1:WIDTH];
   assign prod_lo_o = prod_q[WIDTH-1:0];
   assign flag_z_o  = z_q;
   assign flag_c_o  = c_q;
   assign done_o    = done_q;

   AST_START_STAGES: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> stg_vld); // R7
   AST_STAGE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      stg_vld |=> done_o); // R7
   AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !stg_vld |=> !done_o); // R7
   AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !stg_vld |=> ($stable(prod_hi_o) && $stable(prod_lo_o)
                    && $stable(flag_z_o) && $stable(flag_c_o))); // R8
   AST_FRAC_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (stg_vld && frac_q) |=> (prod_lo_o[0] == 1'b0)); // R4

endmodule

// File: tb/fracmul_unit_bench.sv
module fracmul_unit_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [2:0] mode_i = '0;
   logic [7:0] op_a_i = '0;
   logic [7:0] op_b_i = '0;
   logic [7:0] prod_hi_o, prod_lo_o;
   logic       flag_z_o, flag_c_o, done_o;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   fracmul_unit u_fracmul_unit (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .op_a_i(op_a_i), .op_b_i(op_b_i), .prod_hi_o(prod_hi_o),
      .prod_lo_o(prod_lo_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o),
      .done_o(done_o)
   );

   // expected {c, z, result[15:0]}
   function automatic logic [17:0] model(input logic [7:0] a, input logic [7:0] b,
                                         input logic [2:0] m);
      int sa, sb, p;
      logic [15:0] raw, res;
      sa = int'(a);
      sb = int'(b);
      if ((m[1:0] == 2'b01 || m[1:0] == 2'b10) && a[7]) sa = sa - 256;
      if (m[1:0] == 2'b01 && b[7]) sb = sb - 256;
      p   = sa * sb;
      raw = p[15:0];
      res = m[2] ? {raw[14:0], 1'b0} : raw;
      return {raw[15], (res == 16'h0), res};
   endfunction

   function automatic string req_of(input logic [2:0] m);
      case (m[1:0])
         2'b00: return m[2] ? "R1/R4" : "R1";
         2'b01: return m[2] ? "R2/R4" : "R2";
         2'b10: return m[2] ? "R3/R4" : "R3";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_result(input logic [17:0] e, input string req);
      check({prod_hi_o, prod_lo_o} == e[15:0], req, "product",
            {16'h0, prod_hi_o, prod_lo_o}, {16'h0, e[15:0]});
      check(flag_c_o == e[17], "R5", "carry", {31'h0, flag_c_o}, {31'h0, e[17]});
      check(flag_z_o == e[16], "R6", "zero", {31'h0, flag_z_o}, {31'h0, e[16]});
   endtask

   task automatic run_op(input logic [7:0] a, input logic [7:0] b, input logic [2:0] m,
                         input string req);
      logic [17:0] e;
      e = model(a, b, m);
      @(negedge clk);
      start_i = 1'b1; op_a_i = a; op_b_i = b; mode_i = m;
      @(negedge clk);
      start_i = 1'b0; op_a_i = ~a; op_b_i = b + 8'd3; mode_i = m + 3'd1;
      check(done_o == 1'b0, "R7", "done early", {31'h0, done_o}, 32'h0);
      @(negedge clk);
      check(done_o == 1'b1, "R7", "done at 2", {31'h0, done_o}, 32'h1);
      check_result(e, req);
      @(negedge clk);
      check(done_o == 1'b0, "R7", "done once", {31'h0, done_o}, 32'h0);
      check({prod_hi_o, prod_lo_o} == e[15:0] && flag_c_o == e[17] && flag_z_o == e[16],
            "R8", "hold", {14'h0, flag_c_o, flag_z_o, prod_hi_o, prod_lo_o}, {14'h0, e});
   endtask

   initial begin : watchdog
      while (!finished) begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
         end
      end
   end

   initial begin : stim
      logic [17:0] e1, e2;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check({prod_hi_o, prod_lo_o, flag_z_o, flag_c_o, done_o} == 19'h0, "R9",
            "reset", {13'h0, prod_hi_o, prod_lo_o, flag_z_o, flag_c_o, done_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check({prod_hi_o, prod_lo_o, flag_z_o, flag_c_o, done_o} == 19'h0, "R9",
            "after reset", {13'h0, prod_hi_o, prod_lo_o, flag_z_o, flag_c_o, done_o}, 32'h0);

      // directed corners
      run_op(8'hFF, 8'hFF, 3'd0, "R1");          // FE01, C=1
      run_op(8'h80, 8'h80, 3'd5, "R11");         // -1.0 x -1.0 -> 8000
      check({prod_hi_o, prod_lo_o} == 16'h8000 && !flag_c_o && !flag_z_o, "R11",
            "overflow corner", {14'h0, flag_c_o, flag_z_o, prod_hi_o, prod_lo_o}, 32'h8000);
      run_op(8'h80, 8'h80, 3'd1, "R2");          // 4000
      run_op(8'hFF, 8'h01, 3'd1, "R2");          // FFFF
      run_op(8'h80, 8'hFF, 3'd2, "R3");          // -128*255 = 8080
      run_op(8'h7F, 8'hFF, 3'd6, "R3/R4");
      run_op(8'h00, 8'h5A, 3'd0, "R6");          // zero
      run_op(8'h80, 8'h02, 3'd4, "R4/R6");       // 0100<<1 -> 0200; uu
      run_op(8'h00, 8'h80, 3'd5, "R6");
      run_op(8'hC0, 8'h04, 3'd5, "R4");          // ss frac: FF00<<1, C=1
      run_op(8'hFF, 8'hFF, 3'd3, "R10");
      run_op(8'h90, 8'hF0, 3'd7, "R10");

      // back-to-back starts
      e1 = model(8'h12, 8'h34, 3'd1);
      e2 = model(8'hF1, 8'h7E, 3'd6);
      @(negedge clk);
      start_i = 1'b1; op_a_i = 8'h12; op_b_i = 8'h34; mode_i = 3'd1;
      @(negedge clk);
      op_a_i = 8'hF1; op_b_i = 8'h7E; mode_i = 3'd6;
      check(done_o == 1'b0, "R12", "no early done", {31'h0, done_o}, 32'h0);
      @(negedge clk);
      start_i = 1'b0;
      check(done_o == 1'b1, "R12", "first done", {31'h0, done_o}, 32'h1);
      check_result(e1, "R12");
      @(negedge clk);
      check(done_o == 1'b1, "R12", "second done", {31'h0, done_o}, 32'h1);
      check_result(e2, "R12");
      @(negedge clk);
      check(done_o == 1'b0, "R12", "stream end", {31'h0, done_o}, 32'h0);

      // random
      for (int i = 0; i < 400; i++) begin
         logic [7:0] ra, rb;
         logic [2:0] rm;
         ra = 8'($urandom);
         rb = 8'($urandom);
         rm = 3'($urandom % 8);
         if (i % 16 == 0) ra = 8'h80;
         run_op(ra, rb, rm, req_of(rm));
      end

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule